// File: doc/BRIEF.md
# Bidirectional Port with Key Wake-Up Detector

This block is an 8-bit general-purpose pin port for a small microcontroller bus. Software chooses a direction for each pin, writes an output latch, enables pulls on individual pins and selects push-pull or open-drain drive for the whole port. The pad drive, output enable, pull enable and drive-mode signals go to the pad ring. Pins are modelled as separate digital in, out and output-enable signals.

Reads of the data register return a different source for each pin. Output pins return their latch. Input pins return the synchronized pad level. A key detector takes the AND of every input-mode pin. It pulses an interrupt request when that AND falls from 1 to 0, which happens when a key on an active-low matrix pulls one of those pins low. Output-mode pins are held at 1 inside the AND term, so they can neither trigger the detector nor mask it.

Top module: `gpio_keyport`

## Requirements
- R1: After a synchronous active-low reset, every register reads back 0. No pin is driven (`pad_oe` all 0), `pad_pull` is 0 and `key_irq` is 0.
- R2: The register map is: address 0 = data, 1 = direction, 2 = pull enable, 3 = drive mode. In the direction register, a bit of 1 makes that pin an output and a bit of 0 makes it an input.
- R3: In push-pull mode (drive-mode bit 0 = 0), an output pin has `pad_oe` = 1 and `pad_out` equal to its latch bit.
- R4: Reading address 0 returns the latch bit for each output pin.
- R5: Reading address 0 returns the pad level for each input pin, seen through a two-flop synchronizer.
- R6: Writing address 0 while a pin is an input changes only its latch and leaves the pin undriven. The new value appears on the pad once the pin becomes an output.
- R7: `pad_pull` follows the pull-enable bit on input pins only. It is always 0 on output pins.
- R8: Setting drive-mode bit 0 to 1 selects open-drain drive. Output pins with latch 0 drive low, output pins with latch 1 are released (`pad_oe` = 0), `pad_out` stays 0 and `pad_od` = 1. Bits 7..1 of the drive-mode register read as 0.
- R9: When the AND of all input-mode pins falls from 1 to 0, `key_irq` is high for exactly one clock. The pulse occurs in the cycle after the second rising edge that follows the pad change.
- R10: Output-mode pins count as 1 in the key AND term. Their pad levels neither raise a request nor stop one.
- R11: Out of reset, no request is raised until the AND of the input pins has been seen at 1 for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pull | output | 8 | Pad pull enables |
| pad_od | output | 1 | Open-drain mode indicator to the pads |
| key_irq | output | 1 | One-cycle key interrupt request |

## Verification
The hardest case to reach is a falling AND term in a port where some pins are outputs. It is easy to confuse a low level on an output pin with a key press. The stimulus therefore sets a mixed direction pattern and pulls an output pin's pad low while the input pins stay high. It then releases the pad and drops an input pin. Only the second change must produce exactly one pulse, which is counted over a window. Reset behaviour for R11 is checked with the pads held low from time zero, so a falling edge can never come directly out of reset.

// File: rtl/gpio_keyport_pkg.sv
// Package: shared register addresses for the key wake-up port.
// Assumes a two-bit register address bus.
package gpio_keyport_pkg;
    localparam int REG_ADDR_W = 2;
    localparam logic [REG_ADDR_W-1:0] ADDR_DATA = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_DIR  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_PULL = 2'd2;
    localparam logic [REG_ADDR_W-1:0] ADDR_MODE = 2'd3;
endpackage

// File: rtl/gpio_sync.sv
// Module: multi-stage synchronizer for the asynchronous pad inputs.
// Assumes STAGES >= 2. All flops reset to 0.
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            // Purpose: move the value one stage along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else if (s == 0) chain[s] <= async_in;
                else chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
// Module: register file and readback multiplexer for the port.
// Assumes a single-cycle write strobe and combinational readback.
module gpio_regs
    import gpio_keyport_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [WIDTH-1:0]      bus_wdata,
    input  logic [WIDTH-1:0]      pin_level,
    output logic [WIDTH-1:0]      bus_rdata,
    output logic [WIDTH-1:0]      latch_q,
    output logic [WIDTH-1:0]      dir_q,
    output logic [WIDTH-1:0]      pull_q,
    output logic                  od_q
);
    // Purpose: store the register contents written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
            dir_q   <= '0;
            pull_q  <= '0;
            od_q    <= 1'b0;
        end else if (bus_wr) begin
            case (bus_addr)
                ADDR_DATA: latch_q <= bus_wdata;
                ADDR_DIR:  dir_q   <= bus_wdata;
                ADDR_PULL: pull_q  <= bus_wdata;
                default:   od_q    <= bus_wdata[0];
            endcase
        end
    end

    // Purpose: select the readback source; data mixes latch and pad by direction.
    always_comb begin
        case (bus_addr)
            ADDR_DATA: bus_rdata = (latch_q & dir_q) | (pin_level & ~dir_q);
            ADDR_DIR:  bus_rdata = dir_q;
            ADDR_PULL: bus_rdata = pull_q;
            default:   bus_rdata = {{(WIDTH-1){1'b0}}, od_q};
        endcase
    end

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DIR) |=> (dir_q == $past(bus_wdata)));
endmodule

// File: rtl/gpio_pad_ctrl.sv
// Module: derives pad drive, enable and pull signals from the registers.
// Assumes open-drain is one port-wide select.
module gpio_pad_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pull_q,
    input  logic             od_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pull
);
    // Purpose: open-drain pins only sink; push-pull pins drive the latch.
    always_comb begin
        if (od_q) begin
            pad_out = '0;
            pad_oe  = dir_q & ~latch_q;
        end else begin
            pad_out = latch_q;
            pad_oe  = dir_q;
        end
        pad_pull = pull_q & ~dir_q;
    end

    assert_input_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~dir_q) == '0);
endmodule

// File: rtl/gpio_key_detect.sv
// Module: wired-AND key press detector over the input-mode pins.
// Assumes synchronized pin levels; output pins are masked to 1.
module gpio_key_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_level,
    input  logic [WIDTH-1:0] dir_q,
    output logic             key_irq
);
    logic and_now;
    logic and_prev;

    assign and_now = &(pin_level | dir_q);

    // Purpose: remember last AND value; 0 at reset blocks a false request.
    always_ff @(posedge clk) begin
        if (!rst_n) and_prev <= 1'b0;
        else        and_prev <= and_now;
    end

    assign key_irq = and_prev & ~and_now;

    assert_irq_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        key_irq |=> !key_irq);
endmodule

// File: rtl/gpio_keyport.sv
// Module: top of the 8-bit port with key wake-up request.
// Assumes pads are modelled as separate in/out/oe digital signals.
module gpio_keyport
    import gpio_keyport_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata,
    input  logic [WIDTH-1:0]      pad_in,
    output logic [WIDTH-1:0]      pad_out,
    output logic [WIDTH-1:0]      pad_oe,
    output logic [WIDTH-1:0]      pad_pull,
    output logic                  pad_od,
    output logic                  key_irq
);
    logic [WIDTH-1:0] pin_level;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] pull_q;
    logic             od_q;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_level)
    );

    gpio_regs #(.WIDTH(WIDTH)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .pin_level(pin_level), .bus_rdata(bus_rdata),
        .latch_q(latch_q), .dir_q(dir_q), .pull_q(pull_q), .od_q(od_q)
    );

    gpio_pad_ctrl #(.WIDTH(WIDTH)) i_pad (
        .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .dir_q(dir_q),
        .pull_q(pull_q), .od_q(od_q), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pull(pad_pull)
    );

    gpio_key_detect #(.WIDTH(WIDTH)) i_key (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .dir_q(dir_q),
        .key_irq(key_irq)
    );

    assign pad_od = od_q;

    assert_od_never_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pad_od |-> ((pad_oe & pad_out) == '0));

    assert_pull_inputs_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull & pad_oe) == '0);
endmodule

// File: tb/test_gpio_keyport.sv
module test_gpio_keyport;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pull;
    logic       pad_od, key_irq;

    int checks = 0;
    int errors = 0;
    int irq_count = 0;

    always #5 clk = ~clk;

    gpio_keyport i_gpio_keyport (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull(pad_pull),
        .pad_od(pad_od), .key_irq(key_irq)
    );

    // Count request pulses away from the active edge.
    always @(negedge clk) if (rst_n && key_irq) irq_count++;

    // Vector: dir, latch, pull, mode, pad | exp oe, out, pull, data readback
    typedef struct packed {
        logic [7:0] dir; logic [7:0] lat; logic [7:0] pull; logic od; logic [7:0] pad;
        logic [7:0] e_oe; logic [7:0] e_out; logic [7:0] e_pull; logic [7:0] e_rd;
    } vec_t;
    localparam vec_t VECS [6] = '{
        '{8'hFF, 8'hA5, 8'hFF, 1'b0, 8'h00, 8'hFF, 8'hA5, 8'h00, 8'hA5},
        '{8'h00, 8'h3C, 8'h0F, 1'b0, 8'h96, 8'h00, 8'h3C, 8'h0F, 8'h96},
        '{8'hF0, 8'h5A, 8'hFF, 1'b0, 8'hC3, 8'hF0, 8'h5A, 8'h0F, 8'h53},
        '{8'hFF, 8'h0F, 8'h00, 1'b1, 8'hFF, 8'hF0, 8'h00, 8'h00, 8'h0F},
        '{8'h3C, 8'h24, 8'hC3, 1'b1, 8'h81, 8'h18, 8'h00, 8'hC3, 8'hA5},
        '{8'h0F, 8'hF0, 8'hAA, 1'b0, 8'h5A, 8'h0F, 8'hF0, 8'hA0, 8'h50}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        wait_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), r);
            check("R1 reg readback", r, 8'h00);
        end
        check("R1 pad_oe", pad_oe, 8'h00);
        check("R1 pad_pull", pad_pull, 8'h00);
        check("R1 key_irq", {7'd0, key_irq}, 8'h00);
        // R11: pads low from time zero, no request out of reset
        wait_cycles(5);
        check("R11 no request after reset", 8'(irq_count), 8'd0);
        pad_in = 8'hFF;
        wait_cycles(4);
        check("R11 rising AND gives no request", 8'(irq_count), 8'd0);

        // Table walk: R2 R3 R4 R5 R7 R8
        for (int v = 0; v < 6; v++) begin
            wr(2'd1, VECS[v].dir);
            wr(2'd0, VECS[v].lat);
            wr(2'd2, VECS[v].pull);
            wr(2'd3, {7'd0, VECS[v].od});
            pad_in = VECS[v].pad;
            wait_cycles(3);
            check("R2/R3/R8 pad_oe", pad_oe, VECS[v].e_oe);
            check("R3/R8 pad_out", pad_out, VECS[v].e_out);
            check("R7 pad_pull", pad_pull, VECS[v].e_pull);
            check("R8 pad_od", {7'd0, pad_od}, {7'd0, VECS[v].od});
            rd(2'd0, r);
            check("R4/R5 data readback", r, VECS[v].e_rd);
            rd(2'd1, r);
            check("R2 dir readback", r, VECS[v].dir);
        end

        // R8: upper mode bits read 0
        wr(2'd3, 8'hFF);
        rd(2'd3, r);
        check("R8 mode readback", r, 8'h01);
        wr(2'd3, 8'h00);

        // R6: write latch while input; pin stays undriven, appears on output
        wr(2'd1, 8'h00);
        pad_in = 8'h0F;
        wr(2'd0, 8'h77);
        wait_cycles(3);
        check("R6 undriven after latch write", pad_oe, 8'h00);
        rd(2'd0, r);
        check("R6 readback shows pad", r, 8'h0F);
        wr(2'd1, 8'hFF);
        check("R6 latch on pad after dir", pad_out, 8'h77);
        check("R6 oe after dir", pad_oe, 8'hFF);

        // R5: sync latency, two edges before readback changes
        wr(2'd1, 8'h00);
        pad_in = 8'hFF;
        wait_cycles(3);
        @(negedge clk);
        pad_in = 8'h00;
        @(negedge clk);
        rd(2'd0, r);
        check("R5 one edge: old level", r, 8'hFF);
        @(negedge clk);
        rd(2'd0, r);
        check("R5 two edges: new level", r, 8'h00);

        // R9: single pulse on falling AND, timing checked
        pad_in = 8'hFF;
        wait_cycles(4);
        irq_count = 0;
        pad_in = 8'hF7;
        @(negedge clk);
        check("R9 no pulse after one edge", {7'd0, key_irq}, 8'h00);
        @(negedge clk);
        check("R9 pulse after two edges", {7'd0, key_irq}, 8'h01);
        @(negedge clk);
        check("R9 pulse ends", {7'd0, key_irq}, 8'h00);
        wait_cycles(4);
        check("R9 exactly one pulse", 8'(irq_count), 8'd1);

        // R10: output pins masked in the AND term
        wr(2'd1, 8'hF0);
        pad_in = 8'hFF;
        wait_cycles(4);
        irq_count = 0;
        pad_in = 8'h7F;
        wait_cycles(4);
        check("R10 output pin low gives no request", 8'(irq_count), 8'd0);
        pad_in = 8'h0F;
        wait_cycles(4);
        check("R10 all output pins low no request", 8'(irq_count), 8'd0);
        pad_in = 8'h0B;
        wait_cycles(4);
        check("R10 input pin low still requests", 8'(irq_count), 8'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule